// File: doc/BRIEF.md
# ADC Conversion and Serial-Read Sequencer

This block drives a 12-bit serial-output converter that uses a convert-start strobe and a busy flag. For each sample it lowers the strobe to start a conversion, waits for the busy flag to fall, and then runs a 16-clock serial read. It presents the low 12 bits of the frame on `data_o` together with a one-cycle `valid_o`. Cycles begin on a `start_i` pulse or on an internal sample-rate timer. A request that arrives while a cycle is running is held and served once that cycle is complete.

The converter's power mode is chosen at run time. In the stay-awake mode the strobe is only a short low pulse and is back high before the conversion ends. In the auto-sleep mode the strobe stays low through the end of conversion and through the read, so the converter sleeps. The next cycle first raises the strobe for a wake-up interval before the falling edge that starts the conversion.

All intervals are derived from the system clock frequency parameter and rounded up to whole cycles. The defaults are 50 MHz system clock, 8 µs conversion, 6 µs wake-up, 40 ns strobe-low, 400 ns read guard, 10 MHz serial clock ceiling and 100 kHz sample rate.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A synchronous reset sets `adc_convst_o` high, `adc_sclk_o` low, and `valid_o` and `err_o` low.
- R2: In stay-awake mode (`sleep_mode_i`=0 at cycle start, strobe already high), the strobe falls, stays low for at least 2 cycles (40 ns), and is high again before the busy flag falls.
- R3: End of conversion is taken from the falling edge of `adc_busy_i`, not from a timer. A conversion lasting longer than the nominal 400 cycles still completes normally without an error.
- R4: Each read is exactly 16 pulses on `adc_sclk_o`, which idles low. The converter launches each bit on the rising edge and the block samples on the falling edge. Bits arrive MSB first: four leading bits, then the 12-bit result. `data_o` takes the last 12 bits and ignores the four leading bits. `valid_o` is high for exactly one cycle per read.
- R5: In auto-sleep mode (`sleep_mode_i`=1 at cycle start), the strobe is high for at least 300 cycles (6 µs) before the conversion-starting falling edge. It stays low when busy falls, through the read, and afterwards while idle.
- R6: Every conversion-starting falling edge of the strobe comes at least 20 cycles (400 ns) after the last falling serial clock edge of the previous read.
- R7: A `start_i` pulse that arrives during a running cycle is held and starts exactly one further cycle after the guard time.
- R8: With `timer_en_i` high, cycles start every 500 cycles (the sample period), so successive `valid_o` pulses are exactly 500 cycles apart.
- R9: If busy does not fall within 800 cycles of the conversion-starting edge (1400 in auto-sleep mode), the block sets `err_o`, produces no `valid_o` and returns to idle. `err_o` clears when the next cycle starts.
- R10: A stay-awake cycle that begins with the strobe low (after an auto-sleep cycle) first raises the strobe for the wake-up interval, so a falling edge exists to start the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to run a conversion cycle |
| timer_en_i | input | 1 | Enables the internal sample-period timer |
| sleep_mode_i | input | 1 | 1 selects auto-sleep mode, latched at cycle start |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_sdata_i | input | 1 | Converter serial data |
| adc_convst_o | output | 1 | Convert-start strobe to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | 12 | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when `data_o` is new |
| err_o | output | 1 | Busy timeout flag |

## Verification
The completion of a read and the arrival of a new start request can land in the same cycle. The read completion writes `data_o` and `valid_o` and enters the guard wait, while the request must be stored rather than start a conversion at once. The bench provokes this by pulsing `start_i` during the very cycle in which `valid_o` is high. It then judges that exactly one more conversion follows, that its strobe falling edge respects the 400 ns guard after the last serial clock edge, and that its data is correct.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_LOW,
        ST_BUSY,
        ST_READ,
        ST_GUARD
    } seq_st_e;

    // Round a time in ns up to whole cycles of a clock of hz.
    function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
        return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/adc_period_timer.sv
module adc_period_timer #(
    parameter int unsigned PERIOD_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned TW = $clog2(PERIOD_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tmr_t;

    tmr_t q, n;

    always_comb begin
        n      = q;
        n.tick = 1'b0;
        if (!en_i) begin
            n.cnt = '0;
        end else if (q.cnt == TW'(PERIOD_CYC - 1)) begin
            n.cnt  = '0;
            n.tick = 1'b1;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign tick_o = q.tick;

    // R8: a tick is never followed by another tick on the next cycle
    p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
        q.tick |=> !q.tick);

endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx #(
    parameter int unsigned HALF_CYC = 3,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned OUT_W    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             sdata_i,
    output logic             sclk_o,
    output logic             done_o,
    output logic [OUT_W-1:0] word_o
);
    localparam int unsigned HW = $clog2(HALF_CYC + 1);
    localparam int unsigned BW = $clog2(FRAME_W);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [HW-1:0]    half_cnt;
        logic [BW-1:0]    bit_cnt;
        logic [OUT_W-1:0] shreg;
        logic             done;
    } rx_t;

    rx_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.active) begin
            if (go_i) begin
                n.active   = 1'b1;
                n.sclk     = 1'b0;
                n.half_cnt = '0;
                n.bit_cnt  = '0;
            end
        end else if (q.half_cnt == HW'(HALF_CYC - 1)) begin
            n.half_cnt = '0;
            if (!q.sclk) begin
                n.sclk = 1'b1;
            end else begin
                // falling edge: the bit launched on the rise is stable here
                n.sclk  = 1'b0;
                n.shreg = {q.shreg[OUT_W-2:0], sdata_i};
                if (q.bit_cnt == BW'(FRAME_W - 1)) begin
                    n.active = 1'b0;
                    n.done   = 1'b1;
                end else begin
                    n.bit_cnt = q.bit_cnt + 1'b1;
                end
            end
        end else begin
            n.half_cnt = q.half_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign sclk_o = q.sclk;
    assign done_o = q.done;
    assign word_o = q.shreg;

    // R4: the serial clock rests low whenever no read is running
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !q.active |-> !q.sclk);

    // R4: completion is a single-cycle event
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SCLK_HZ   = 10_000_000,
    parameter int unsigned SAMPLE_HZ = 100_000,
    parameter int unsigned CONV_NS   = 8000,
    parameter int unsigned WAKE_NS   = 6000,
    parameter int unsigned LOW_NS    = 40,
    parameter int unsigned GUARD_NS  = 400,
    parameter int unsigned FRAME_W   = 16,
    parameter int unsigned DATA_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              timer_en_i,
    input  logic              sleep_mode_i,
    input  logic              adc_busy_i,
    input  logic              adc_sdata_i,
    output logic              adc_convst_o,
    output logic              adc_sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int unsigned LOW_RAW    = ns2cyc(LOW_NS, CLK_HZ);
    localparam int unsigned LOW_CYC    = (LOW_RAW < 1) ? 1 : LOW_RAW;
    localparam int unsigned CONV_CYC   = ns2cyc(CONV_NS, CLK_HZ);
    localparam int unsigned WAKE_RAW   = ns2cyc(WAKE_NS, CLK_HZ);
    localparam int unsigned WAKE_CYC   = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int unsigned GUARD_RAW  = ns2cyc(GUARD_NS, CLK_HZ);
    localparam int unsigned GUARD_CYC  = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
    localparam int unsigned HALF_CYC   = (CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
    localparam int unsigned PERIOD_CYC = CLK_HZ / SAMPLE_HZ;
    localparam int unsigned TMO_FAST   = 2 * CONV_CYC;
    localparam int unsigned TMO_SLEEP  = 2 * (WAKE_CYC + CONV_CYC);
    localparam int unsigned CW         = $clog2(TMO_SLEEP + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              convst;
        logic              sleep;
        logic [CW-1:0]     cnt;
        logic              busy_s;
        logic              busy_p;
        logic              pend;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              err;
        logic              go;
    } ctl_t;

    ctl_t q, n;

    logic              tick;
    logic              rx_done;
    logic [DATA_W-1:0] rx_word;
    logic              req;

    adc_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en_i   (timer_en_i),
        .tick_o (tick)
    );

    adc_serial_rx #(.HALF_CYC(HALF_CYC), .FRAME_W(FRAME_W), .OUT_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .go_i    (q.go),
        .sdata_i (adc_sdata_i),
        .sclk_o  (adc_sclk_o),
        .done_o  (rx_done),
        .word_o  (rx_word)
    );

    assign req = start_i | tick;

    always_comb begin
        n        = q;
        n.valid  = 1'b0;
        n.go     = 1'b0;
        n.busy_s = adc_busy_i;
        n.busy_p = q.busy_s;
        if (req) n.pend = 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (q.pend || req) begin
                    n.pend  = 1'b0;
                    n.err   = 1'b0;
                    n.sleep = sleep_mode_i;
                    n.cnt   = '0;
                    if (sleep_mode_i || !q.convst) begin
                        n.st     = ST_WAKE;
                        n.convst = 1'b1;
                    end else begin
                        n.st     = ST_LOW;
                        n.convst = 1'b0;
                    end
                end
            end
            ST_WAKE: begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(WAKE_CYC - 1)) begin
                    n.st     = ST_LOW;
                    n.convst = 1'b0;
                    n.cnt    = '0;
                end
            end
            ST_LOW: begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(LOW_CYC - 1)) begin
                    n.st = ST_BUSY;
                    if (!q.sleep) n.convst = 1'b1;
                end
            end
            ST_BUSY: begin
                n.cnt = q.cnt + 1'b1;
                if (q.busy_p && !q.busy_s) begin
                    n.st = ST_READ;
                    n.go = 1'b1;
                end else if (q.cnt >= (q.sleep ? CW'(TMO_SLEEP) : CW'(TMO_FAST))) begin
                    n.err = 1'b1;
                    n.st  = ST_IDLE;
                end
            end
            ST_READ: begin
                if (rx_done) begin
                    n.data  = rx_word;
                    n.valid = 1'b1;
                    n.cnt   = '0;
                    n.st    = ST_GUARD;
                end
            end
            ST_GUARD: begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(GUARD_CYC - 1)) n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.convst <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign adc_convst_o = q.convst;
    assign data_o       = q.data;
    assign valid_o      = q.valid;
    assign err_o        = q.err;

    // Checking support: cycles the strobe has been high, cycles since a read ended.
    logic [CW-1:0] hi_run_q;
    logic [CW-1:0] since_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q   <= '0;
            since_rd_q <= CW'(GUARD_CYC);
        end else begin
            if (!n.convst)            hi_run_q <= '0;
            else if (!q.convst)       hi_run_q <= CW'(1);
            else if (hi_run_q != '1)  hi_run_q <= hi_run_q + 1'b1;
            if (rx_done)                since_rd_q <= '0;
            else if (since_rd_q != '1)  since_rd_q <= since_rd_q + 1'b1;
        end
    end

    // R5: the wake-up interval precedes every auto-sleep conversion start
    p_wake_len_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(q.convst) && q.sleep) |-> ($past(hi_run_q) >= CW'(WAKE_CYC)));

    // R5: the strobe stays low while waiting and reading in auto-sleep mode
    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (q.sleep && (q.st == ST_BUSY || q.st == ST_READ)) |-> !q.convst);

    // R2: in stay-awake mode the strobe is back high while waiting for busy
    p_fast_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!q.sleep && q.st == ST_BUSY) |-> q.convst);

    // R6: a conversion start never violates the read guard
    p_guard_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(q.convst) |-> (since_rd_q >= CW'(GUARD_CYC)));

    // R4: the result strobe lasts one cycle
    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        q.valid |=> !q.valid);

    // R9: a timeout never coincides with a result
    p_err_noval_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(q.err) |-> !q.valid);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int LOW_E   = 2;    // 40 ns at 20 ns/cycle
    localparam int WAKE_E  = 300;  // 6 us
    localparam int GUARD_E = 20;   // 400 ns
    localparam int PER_E   = 500;  // 100 kHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic timer_en_i = 1'b0;
    logic sleep_mode_i = 1'b0;
    logic adc_busy_i;
    logic adc_sdata_i;
    logic adc_convst_o;
    logic adc_sclk_o;
    logic [11:0] data_o;
    logic valid_o;
    logic err_o;

    always #10 clk = ~clk;

    adc_seq_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .timer_en_i   (timer_en_i),
        .sleep_mode_i (sleep_mode_i),
        .adc_busy_i   (adc_busy_i),
        .adc_sdata_i  (adc_sdata_i),
        .adc_convst_o (adc_convst_o),
        .adc_sclk_o   (adc_sclk_o),
        .data_o       (data_o),
        .valid_o      (valid_o),
        .err_o        (err_o)
    );

    // ---------------- converter model ----------------
    int        conv_cyc = 300;
    bit        stuck = 1'b0;
    logic [3:0]  lead = 4'h0;
    logic [11:0] sample = 12'h000;
    logic      cv_prev = 1'b1;
    int        bcnt = 0;
    logic      lvl_at_bfall = 1'b0;
    int        idx = 0;

    initial adc_busy_i = 1'b0;
    initial adc_sdata_i = 1'b0;

    always @(posedge clk) begin
        cv_prev <= adc_convst_o;
        if (cv_prev && !adc_convst_o) begin
            adc_busy_i <= 1'b1;
            bcnt       <= conv_cyc;
        end else if (adc_busy_i && !stuck) begin
            if (bcnt <= 1) begin
                adc_busy_i   <= 1'b0;
                lvl_at_bfall <= adc_convst_o;
            end else begin
                bcnt <= bcnt - 1;
            end
        end
    end

    always @(posedge adc_sclk_o) begin
        logic [15:0] frame;
        frame = {lead, sample};
        adc_sdata_i <= frame[15 - idx];
        idx <= (idx == 15) ? 0 : idx + 1;
    end

    // ---------------- port monitors ----------------
    int  cyc = 0;
    logic cp = 1'b1, sp = 1'b0, vp = 1'b0;
    int  hi_len = 0, lo_len = 0, last_hi = 0, last_lo = 0;
    int  falls = 0, sfalls = 0, since_sf = 1000, gap_at_fall = 0;
    int  vcnt = 0, vbad = 0, vtime = 0, prev_vtime = 0;
    logic [11:0] vdata = 12'h0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (adc_convst_o) begin
                hi_len <= cp ? hi_len + 1 : 1;
                lo_len <= 0;
                if (!cp) last_lo <= lo_len;
            end else begin
                lo_len <= cp ? 1 : lo_len + 1;
                hi_len <= 0;
                if (cp) begin
                    last_hi     <= hi_len;
                    falls       <= falls + 1;
                    gap_at_fall <= since_sf;
                end
            end
            if (sp && !adc_sclk_o) begin
                sfalls   <= sfalls + 1;
                since_sf <= 0;
            end else begin
                since_sf <= since_sf + 1;
            end
            if (valid_o) begin
                vcnt       <= vcnt + 1;
                vdata      <= data_o;
                prev_vtime <= vtime;
                vtime      <= cyc;
                if (vp) vbad <= vbad + 1;
            end
        end
        cp <= adc_convst_o;
        sp <= adc_sclk_o;
        vp <= valid_o;
    end

    // ---------------- check bookkeeping ----------------
    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_vcnt(input int target, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (vcnt >= target) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic idle_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        idle_cycles(4);
        chk(adc_convst_o === 1'b1, "R1 convst", adc_convst_o, 1);
        chk(adc_sclk_o === 1'b0, "R1 sclk", adc_sclk_o, 0);
        chk(valid_o === 1'b0, "R1 valid", valid_o, 0);
        chk(err_o === 1'b0, "R1 err", err_o, 0);
        rst = 1'b0;
        idle_cycles(4);
    endtask

    task automatic t_fast(input logic [11:0] val, input logic [3:0] ld, input string tag);
        int v0, s0;
        bit ok;
        sample = val; lead = ld; sleep_mode_i = 1'b0;
        v0 = vcnt; s0 = sfalls;
        pulse_start();
        wait_vcnt(v0 + 1, 3000, ok);
        idle_cycles(30);
        chk(ok, {tag, " R4 valid seen"}, ok, 1);
        chk(vdata == val, {tag, " R4 data"}, vdata, val);
        chk(sfalls - s0 == 16, {tag, " R4 sclk count"}, sfalls - s0, 16);
        chk(vcnt - v0 == 1 && vbad == 0, {tag, " R4 single valid"}, vcnt - v0, 1);
        chk(last_lo >= LOW_E, {tag, " R2 low width"}, last_lo, LOW_E);
        chk(lvl_at_bfall == 1'b1, {tag, " R2 strobe high at busy fall"}, lvl_at_bfall, 1);
    endtask

    task automatic t_long_conv();
        int v0;
        bit ok;
        conv_cyc = 560;
        v0 = vcnt; sample = 12'h5A3; lead = 4'h0;
        pulse_start();
        wait_vcnt(v0 + 1, 3000, ok);
        idle_cycles(30);
        chk(ok && vdata == 12'h5A3, "R3 long conversion data", vdata, 12'h5A3);
        chk(err_o == 1'b0, "R3 no error", err_o, 0);
        conv_cyc = 300;
    endtask

    task automatic t_sleep();
        int v0;
        bit ok;
        sleep_mode_i = 1'b1; sample = 12'h7E2;
        v0 = vcnt;
        pulse_start();
        wait_vcnt(v0 + 1, 4000, ok);
        idle_cycles(40);
        chk(last_hi >= WAKE_E, "R5 wake interval", last_hi, WAKE_E);
        chk(lvl_at_bfall == 1'b0, "R5 strobe low at busy fall", lvl_at_bfall, 0);
        chk(ok && vdata == 12'h7E2, "R5 sleep data", vdata, 12'h7E2);
        chk(adc_convst_o == 1'b0, "R5 strobe low after cycle", adc_convst_o, 0);
    endtask

    task automatic t_wake_first();
        int v0, f0;
        bit ok;
        sleep_mode_i = 1'b0; sample = 12'h19C;
        v0 = vcnt; f0 = falls;
        pulse_start();
        wait_vcnt(v0 + 1, 4000, ok);
        idle_cycles(30);
        chk(falls - f0 == 1, "R10 one start edge", falls - f0, 1);
        chk(last_hi >= WAKE_E, "R10 wake before start", last_hi, WAKE_E);
        chk(ok && vdata == 12'h19C, "R10 data", vdata, 12'h19C);
        chk(adc_convst_o == 1'b1, "R10 strobe high after cycle", adc_convst_o, 1);
    endtask

    task automatic t_held_request();
        int v0, f0;
        bit ok;
        sleep_mode_i = 1'b0; sample = 12'hC3E;
        v0 = vcnt; f0 = falls;
        pulse_start();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (valid_o) break;
        end
        start_i = 1'b1;   // lands in the cycle the result is delivered
        @(negedge clk) start_i = 1'b0;
        wait_vcnt(v0 + 2, 3000, ok);
        idle_cycles(600);
        chk(ok, "R7 held request served", vcnt - v0, 2);
        chk(falls - f0 == 2, "R7 exactly one extra cycle", falls - f0, 2);
        chk(gap_at_fall >= GUARD_E, "R6 guard before next start", gap_at_fall, GUARD_E);
        chk(vdata == 12'hC3E, "R7 second data", vdata, 12'hC3E);
    endtask

    task automatic t_timeout();
        int v0;
        bit ok;
        sleep_mode_i = 1'b0;
        stuck = 1'b1;
        v0 = vcnt;
        pulse_start();
        idle_cycles(1000);
        chk(err_o == 1'b1, "R9 error set", err_o, 1);
        chk(vcnt == v0, "R9 no valid", vcnt - v0, 0);
        stuck = 1'b0;
        idle_cycles(conv_cyc + 20);
        sample = 12'h2B7;
        pulse_start();
        idle_cycles(5);
        chk(err_o == 1'b0, "R9 error cleared on new cycle", err_o, 0);
        wait_vcnt(v0 + 1, 3000, ok);
        idle_cycles(30);
        chk(ok && vdata == 12'h2B7, "R9 recovery data", vdata, 12'h2B7);
    endtask

    task automatic t_timer();
        int v0;
        bit ok;
        sleep_mode_i = 1'b0; sample = 12'h0F0;
        v0 = vcnt;
        @(negedge clk) timer_en_i = 1'b1;
        wait_vcnt(v0 + 2, 2000, ok);
        chk(ok && vtime - prev_vtime == PER_E, "R8 first interval", vtime - prev_vtime, PER_E);
        wait_vcnt(v0 + 3, 2000, ok);
        chk(ok && vtime - prev_vtime == PER_E, "R8 second interval", vtime - prev_vtime, PER_E);
        @(negedge clk) timer_en_i = 1'b0;
        idle_cycles(1000);
        chk(vdata == 12'h0F0, "R8 timer data", vdata, 12'h0F0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fast(12'hA5C, 4'h0, "fast1");
        t_fast(12'h3C1, 4'hF, "fast2");
        t_fast(12'hFFF, 4'h0, "fast3");
        t_long_conv();
        t_sleep();
        t_wake_first();
        t_held_request();
        t_timeout();
        t_timer();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule